// File: doc/BRIEF.md
# SMBus alert response responder

This block lets a device that is holding its shared interrupt line active identify itself to the bus master. It watches SCL and the data input for a START followed by the alert response header (seven-bit address 0001100 with the read bit set). If the device's own alert is pending at that moment, the block acknowledges. It then shifts out the device's seven-bit bus address, a fixed upper part followed by the strap bits, and ends with a trailing 1.

Several devices may answer the same cycle. Each sends its address over the wired-AND data line and checks every bit it sends. A device that sends a 1 but samples a 0 drops off the bus at once. It waits for a later alert response cycle to try again, so the device with the lowest address wins. When a transfer completes, the block emits a one-cycle pulse at the closing STOP. The interrupt logic uses that pulse to release its line, so the line only changes between transactions.

The block shares SCL, the data input and the data-low output enable with the device's register slave. From the matched header until the next START or STOP, it owns the output enable and tells the register slave to keep off the cycle. At all other times the register slave's enable passes straight through.

Top module: `smbus_ara_responder`

## Requirements
- R1: Only the header byte 0x19 (address 0001100, read bit 1, sent MSB first) is taken as an alert response cycle. Any other header produces no acknowledge, no drive and no ownership indication.
- R2: After a matching header, the block pulls the data line low during the acknowledge clock only if the alert-pending input is high at the SCL fall that ends the header. Otherwise it stays silent for the rest of the cycle.
- R3: After acknowledging, the block sends eight bits MSB first: 010, then the four strap bits, then 1. A 0 is sent by driving low and a 1 by releasing. The driven value changes only after an SCL fall, a START or a STOP.
- R4: While sending, if the block is sending a 1 and samples 0 on an SCL rise, it stops driving for the rest of the cycle. The byte the master sees is then the lower competing address.
- R5: A device that lost arbitration answers the next alert response cycle normally.
- R6: After the eighth transmitted bit, the block releases the data line and ignores the master's acknowledge, whether it is 0 or 1.
- R7: A won transfer produces exactly one single-cycle release pulse at the following STOP. A lost, unacknowledged or non-matching cycle produces none.
- R8: From the header match until the next START or STOP, the ownership output is high and the register slave's output enable is blocked. Outside that window, the output enable equals the register slave's enable.
- R9: After reset, the output enable, the ownership output and the release pulse are all low.
- R10: A repeated START in the middle of a transaction restarts header decoding from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| alert_pending_i | input | 1 | High while the device asserts its interrupt line |
| addr_lo_i | input | LO_W | Strapped low bits of the device's bus address |
| reg_sda_oe_i | input | 1 | Data-low enable requested by the register slave |
| sda_oe_o | output | 1 | Data-low enable to the pad (1 pulls the line low) |
| ara_active_o | output | 1 | High while an alert response cycle owns the bus; the register slave ignores the cycle |
| alert_release_o | output | 1 | One-cycle pulse: a transfer was won, the interrupt may be released |

## Verification
The bench builds the block with its defaults: four strap bits and a two-stage input synchronizer. With only sixteen possible strap values, the sweep can cover every pairing of own address and competing address. A bench model of a rival responder competes on the same wired-AND line, so ties, wins and losses at every bit position are all exercised. Each loss is followed by a retry. Every single-bit corruption of the header is tried as well. The master's final acknowledge alternates between 0 and 1 across the sweep.

// File: rtl/ara_pkg.sv
// Shared constants and state encoding for the alert response responder.
// Assumes a seven-bit bus address and eight-bit bytes.
package ara_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // no transaction of interest
        ST_HDR    = 3'd1,  // shifting in the header byte
        ST_DECIDE = 3'd2,  // header matched, waiting for SCL fall to ack
        ST_ACK    = 3'd3,  // holding the acknowledge low
        ST_SEND   = 3'd4,  // transmitting own address with arbitration
        ST_TAIL   = 3'd5,  // transfer won, master acknowledge ignored
        ST_OUT    = 3'd6   // silent until next START or STOP
    } ara_st_e;

endpackage

// File: rtl/ara_bus_cond.sv
// Synchronizes SCL and the data input to clk and derives SCL edges and
// START/STOP conditions. Assumes clk is several times faster than SCL.
// Sync flops reset to 1, the idle bus level.
module ara_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;

    // Synchronizer chains for both bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync[0] <= scl_i;
            sda_sync[0] <= sda_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                scl_sync[k] <= scl_sync[k-1];
                sda_sync[k] <= sda_sync[k-1];
            end
        end
    end

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/ara_engine.sv
// Bit-level sequencer for the alert response cycle: header decode,
// conditional acknowledge, address transmission with wired-AND
// arbitration, and the release report deferred to STOP.
// Assumes event inputs are single-cycle pulses from ara_bus_cond.
module ara_engine
    import ara_pkg::*;
#(
    parameter int                  LO_W    = 4,
    parameter logic [ADDR_W-LO_W-1:0] HI_BITS = 3'b010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            alert_pending_i,
    input  logic [LO_W-1:0] addr_lo_i,
    output logic            ara_drv_o,
    output logic            ara_active_o,
    output logic            release_o,
    output ara_st_e         st_o
);

    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] ARA_HDR  = {ALERT_ADDR, 1'b1};

    ara_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    logic              drv;
    logic              active;
    logic              won;
    logic              rel;
    logic [BYTE_W-1:0] rx_next;

    // Header byte including the bit being sampled now.
    assign rx_next = {rx[BYTE_W-2:0], sda_s};

    // Main sequencer: START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            drv    <= 1'b0;
            active <= 1'b0;
            won    <= 1'b0;
            rel    <= 1'b0;
        end else begin
            rel <= 1'b0;
            if (start_det) begin
                st     <= ST_HDR;
                cnt    <= '0;
                drv    <= 1'b0;
                active <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                drv    <= 1'b0;
                active <= 1'b0;
                if (won) begin
                    rel <= 1'b1;
                    won <= 1'b0;
                end
            end else begin
                case (st)
                    ST_HDR: begin
                        if (scl_rise) begin
                            rx  <= rx_next;
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                if (rx_next == ARA_HDR) begin
                                    active <= 1'b1;
                                    st     <= ST_DECIDE;
                                end else begin
                                    st <= ST_OUT;
                                end
                            end
                        end
                    end
                    ST_DECIDE: begin
                        if (scl_fall) begin
                            if (alert_pending_i) begin
                                drv <= 1'b1;
                                tx  <= {HI_BITS, addr_lo_i, 1'b1};
                                st  <= ST_ACK;
                            end else begin
                                st <= ST_OUT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            drv <= ~tx[BYTE_W-1];
                            cnt <= '0;
                            st  <= ST_SEND;
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            if (tx[BYTE_W-1] && !sda_s) begin
                                drv <= 1'b0;
                                st  <= ST_OUT;
                            end else if (cnt == LAST_BIT) begin
                                won <= 1'b1;
                                drv <= 1'b0;
                                st  <= ST_TAIL;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (scl_fall) begin
                            tx  <= {tx[BYTE_W-2:0], 1'b0};
                            drv <= ~tx[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ara_drv_o    = drv;
    assign ara_active_o = active;
    assign release_o    = rel;
    assign st_o         = st;

endmodule

// File: rtl/ara_oe_select.sv
// Chooses who owns the data-low enable: the responder while an alert
// response cycle is active, the register slave otherwise.
module ara_oe_select (
    input  logic ara_active,
    input  logic ara_drv,
    input  logic reg_sda_oe,
    output logic sda_oe
);

    // Ownership mux.
    always_comb begin
        sda_oe = ara_active ? ara_drv : reg_sda_oe;
    end

endmodule

// File: rtl/smbus_ara_responder.sv
// Top of the alert response responder. Ties the synchronizer, the
// sequencer and the output-enable owner together. Assumes an
// open-drain pad where sda_oe_o = 1 pulls the line low.
module smbus_ara_responder
    import ara_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter int                  LO_W        = 4,
    parameter logic [ADDR_W-LO_W-1:0] HI_BITS  = 3'b010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic            alert_pending_i,
    input  logic [LO_W-1:0] addr_lo_i,
    input  logic            reg_sda_oe_i,
    output logic            sda_oe_o,
    output logic            ara_active_o,
    output logic            alert_release_o
);

    logic    w_sda_s;
    logic    w_scl_rise;
    logic    w_scl_fall;
    logic    w_start;
    logic    w_stop;
    logic    w_drv;
    logic    w_active;
    ara_st_e w_st;

    ara_bus_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (w_sda_s),
        .scl_rise (w_scl_rise),
        .scl_fall (w_scl_fall),
        .start_det(w_start),
        .stop_det (w_stop)
    );

    ara_engine #(
        .LO_W   (LO_W),
        .HI_BITS(HI_BITS)
    ) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .sda_s          (w_sda_s),
        .scl_rise       (w_scl_rise),
        .scl_fall       (w_scl_fall),
        .start_det      (w_start),
        .stop_det       (w_stop),
        .alert_pending_i(alert_pending_i),
        .addr_lo_i      (addr_lo_i),
        .ara_drv_o      (w_drv),
        .ara_active_o   (w_active),
        .release_o      (alert_release_o),
        .st_o           (w_st)
    );

    ara_oe_select u_sel (
        .ara_active(w_active),
        .ara_drv   (w_drv),
        .reg_sda_oe(reg_sda_oe_i),
        .sda_oe    (sda_oe_o)
    );

    assign ara_active_o = w_active;

endmodule

// File: rtl/ara_responder_chk.sv
// Property checker for smbus_ara_responder, attached by bind below.
module ara_responder_chk
    import ara_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    scl_fall,
    input logic    start_det,
    input logic    stop_det,
    input logic    alert_pending,
    input logic    ara_drv,
    input logic    ara_active,
    input logic    reg_oe,
    input logic    sda_oe,
    input logic    release_p,
    input ara_st_e st
);

    // R8
    drive_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ara_drv |-> ara_active);

    // R8
    reg_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_active && reg_oe && !ara_drv) |-> !sda_oe);

    // R3
    drive_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ara_drv) |-> $past(scl_fall || start_det || stop_det));

    // R7
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_p |=> !release_p);

    // R7
    release_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_p |-> $past(stop_det));

    // R2
    ack_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && $past(st) != ST_ACK) |-> $past(alert_pending));

    // R4
    silent_after_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OUT) |-> !ara_drv);

endmodule

bind smbus_ara_responder ara_responder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_fall     (w_scl_fall),
    .start_det    (w_start),
    .stop_det     (w_stop),
    .alert_pending(alert_pending_i),
    .ara_drv      (w_drv),
    .ara_active   (w_active),
    .reg_oe       (reg_sda_oe_i),
    .sda_oe       (sda_oe_o),
    .release_p    (alert_release_o),
    .st           (w_st)
);

// File: tb/test_smbus_ara_responder.sv
module test_smbus_ara_responder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       m_sda;
    logic       c_sda;
    logic       pend;
    logic [3:0] addr_lo;
    logic       reg_oe;
    logic       sda_oe;
    logic       act;
    logic       rel;
    logic       bus_sda;
    int         total = 0;
    int         bad = 0;
    int         rel_cnt = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    assign bus_sda = m_sda & c_sda & ~sda_oe;

    smbus_ara_responder i_smbus_ara_responder (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl),
        .sda_i          (bus_sda),
        .alert_pending_i(pend),
        .addr_lo_i      (addr_lo),
        .reg_sda_oe_i   (reg_oe),
        .sda_oe_o       (sda_oe),
        .ara_active_o   (act),
        .alert_release_o(rel)
    );

    always @(posedge clk) if (rst_n && rel) rel_cnt++;

    task automatic chk(input bit ok, input string req, input int a, input int e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        wt(1); m_sda = 1'b1; wt(5); scl = 1'b1; wt(6); m_sda = 1'b0; wt(6); scl = 1'b0;
    endtask

    task automatic bstop();
        wt(1); m_sda = 1'b0; wt(5); scl = 1'b1; wt(6); m_sda = 1'b1; wt(6);
    endtask

    task automatic sbit(input logic mb, input logic cb, output logic rb,
                        output logic oe, output logic ac);
        wt(1); m_sda = mb; c_sda = cb; wt(5); scl = 1'b1; wt(3);
        rb = bus_sda; oe = sda_oe; ac = act;
        wt(3); scl = 1'b0;
    endtask

    task automatic ara_txn(input logic [7:0] hdr, input bit cp, input logic [3:0] ca,
                           input logic mack, input bit reg_hold,
                           output logic ackd, output logic [7:0] rd,
                           output logic act_ack, output logic oe_tail);
        logic rb, oe, ac, cb, clive;
        logic [7:0] cbyte;
        bstart();
        for (int i = 7; i >= 0; i--) sbit(hdr[i], 1'b1, rb, oe, ac);
        if (reg_hold) reg_oe = 1'b1;
        sbit(1'b1, cp ? 1'b0 : 1'b1, rb, oe, ac);
        ackd = !rb; act_ack = ac;
        clive = cp; cbyte = {3'b010, ca, 1'b1};
        for (int i = 7; i >= 0; i--) begin
            cb = clive ? cbyte[i] : 1'b1;
            sbit(1'b1, cb, rb, oe, ac);
            rd[i] = rb;
            if (clive && cb && !rb) clive = 1'b0;
        end
        sbit(mack, 1'b1, rb, oe, ac);
        oe_tail = oe;
        reg_oe = 1'b0; c_sda = 1'b1;
        bstop(); wt(6);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ackd, act_ack, oe_tail, rb, oe, ac;
        logic [7:0] rd, exp_rd;
        int r0;
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; c_sda = 1'b1;
        pend = 1'b0; addr_lo = 4'h0; reg_oe = 1'b0;
        wt(5); rst_n = 1'b1; wt(4);
        // R9 reset state
        chk(sda_oe == 1'b0, "R9 oe", sda_oe, 0);
        chk(act == 1'b0, "R9 active", act, 0);
        chk(rel == 1'b0, "R9 release", rel, 0);

        // R8 idle passthrough of the register slave enable
        reg_oe = 1'b1; wt(2);
        chk(sda_oe == 1'b1, "R8 passthrough", sda_oe, 1);
        reg_oe = 1'b0; wt(2);
        chk(sda_oe == 1'b0, "R8 passthrough off", sda_oe, 0);

        // R1 every single-bit corruption of the header 0x19
        pend = 1'b1; addr_lo = 4'h3;
        for (int k = 0; k < 8; k++) begin
            r0 = rel_cnt;
            ara_txn(8'h19 ^ (8'h1 << k), 0, 4'h0, 1'b1, 0, ackd, rd, act_ack, oe_tail);
            chk(!ackd, "R1 ack", ackd, 0);
            chk(!act_ack, "R1 active", act_ack, 0);
            chk(rd == 8'hFF, "R1 data", rd, 8'hFF);
            chk(rel_cnt == r0, "R7 no release", rel_cnt - r0, 0);
        end

        // R2 / R8 alert not pending, register slave tries to drive
        pend = 1'b0; r0 = rel_cnt;
        ara_txn(8'h19, 0, 4'h0, 1'b1, 1, ackd, rd, act_ack, oe_tail);
        chk(!ackd, "R2 no ack", ackd, 0);
        chk(act_ack, "R8 active", act_ack, 1);
        chk(rd == 8'hFF, "R8 blocked data", rd, 8'hFF);
        chk(rel_cnt == r0, "R7 no release", rel_cnt - r0, 0);

        // R3 R4 R5 R6 R7 full sweep of own vs competing address
        pend = 1'b1;
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 16; c++) begin
                addr_lo = 4'(a); r0 = rel_cnt;
                ara_txn(8'h19, 1, 4'(c), 1'((a ^ c) & 1), 0, ackd, rd, act_ack, oe_tail);
                exp_rd = {3'b010, 4'((a < c) ? a : c), 1'b1};
                chk(ackd, "R2 ack", ackd, 1);
                chk(rd == exp_rd, "R4 arbitration", rd, exp_rd);
                chk(!oe_tail, "R6 tail", oe_tail, 0);
                chk(rel_cnt - r0 == ((a <= c) ? 1 : 0), "R7 release", rel_cnt - r0, (a <= c) ? 1 : 0);
                if (a > c) begin
                    r0 = rel_cnt;
                    ara_txn(8'h19, 0, 4'h0, 1'b0, 0, ackd, rd, act_ack, oe_tail);
                    exp_rd = {3'b010, 4'(a), 1'b1};
                    chk(rd == exp_rd, "R5 retry data", rd, exp_rd);
                    chk(rel_cnt - r0 == 1, "R5 retry release", rel_cnt - r0, 1);
                end
            end
        end

        // R10 repeated START mid header
        addr_lo = 4'hA; r0 = rel_cnt;
        bstart();
        for (int i = 0; i < 4; i++) sbit(1'b0, 1'b1, rb, oe, ac);
        ara_txn(8'h19, 0, 4'h0, 1'b1, 0, ackd, rd, act_ack, oe_tail);
        chk(ackd, "R10 ack", ackd, 1);
        chk(rd == 8'h55, "R10 data", rd, 8'h55);
        chk(rel_cnt - r0 == 1, "R10 release", rel_cnt - r0, 1);
        chk(sda_oe == 1'b0 && act == 1'b0, "R8 idle after stop", {sda_oe, act}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule